// File: doc/BRIEF.md
# Delayed Read Restart and Flush Controller

An external bus master asks the host for a read. The bus side retries that master, and the read becomes a delayed read. This controller tracks the read from that point until it ends. It captures the start address and the byte enables of the request. While the read is pending, it compares every completed bus write with the window of words the read covers. When a write lands inside that window, the controller sends a restart response to the host. It then discards stale entries from the tagged read-data FIFO that the host fills. The host must close each restart with a terminating entry.

After the earlier writes have drained, the controller sends a resume response. From then on it moves entries from the FIFO to the target data path. The target path receives:
- valid data, with parity-error and last markers;
- target aborts;
- fast retries;
- a disconnect on every data phase that asks for less than a full word.

A read whose master stops returning for too long is discarded, and a report response goes to the host. Bus protocol timing, address decode and the FIFO storage are outside the block.

Top module: `delayedReadCtl`

## Requirements
- R1: After reset the block is idle. All target outputs, `rspValid` and `fifoPop` are low, and FIFO entries other than spares are left in place.
- R2: While a read is pending, a completed write overlaps the read if its byte address falls in the range from the 4-byte-aligned start address up to `WINDOW_WORDS` words beyond it (not inclusive). On overlap, the next cycle carries a one-cycle response with code 4'h8 and data equal to the captured start address. A write outside the range produces no response.
- R3: After a restart, the block pops every FIFO entry, without waiting for `tgtReady` and without forwarding anything. It stops after the first terminating entry, which is tag 3'b110, 3'b111 or 3'b001, and pops that entry too. Later entries serve the read.
- R4: Each overlap seen during flushing, including one seen in the flush itself, needs one more terminating entry. The flush ends only after every restart has been matched. It then returns to service if the resume response was already sent, and otherwise to waiting.
- R5: While waiting, a high `writesDrained` produces a single response with code 4'h9, carrying the start address, and the block enters service.
- R6: In service, an entry with tag bit 2 set is popped only while `tgtReady` is high. The next cycle shows `tgtValid` with the entry data, `tgtPerr` equal to tag bit 0 and `tgtLast` equal to tag bit 1. A last entry ends the read.
- R7: A forwarded data phase raises `tgtDisconnect` when the captured active-low byte enables are not 4'b0000.
- R8: Tag 3'b001 in service produces a one-cycle `tgtAbort` and ends the read.
- R9: Tag 3'b011 in service produces a one-cycle `tgtRetry`. The read stays in service.
- R10: Spare tags 3'b000 and 3'b010 are popped in every state whenever they reach the head of the FIFO, and they produce no output.
- R11: While waiting or in service, a read whose master does not present the same address again within `TIMEOUT_CYCLES` cycles is discarded. The block emits code 4'h3 with only data bit 18 set and goes idle. Presenting the same address again restarts the count.
- R12: A read request with a different address while a read is pending is ignored. The captured address and window stay unchanged.
- R13: In one cycle, a timeout takes priority over a restart, and a restart takes priority over the resume response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdReqValid | input | 1 | External master presents a read |
| rdReqAddr | input | ADDR_W | Byte address of the presented read |
| rdReqBeN | input | 4 | Active-low byte enables of the read |
| writesDrained | input | 1 | All writes queued ahead of the read have finished |
| wrDoneValid | input | 1 | A bus write completed this cycle |
| wrDoneAddr | input | ADDR_W | Byte address of the completed write |
| fifoValid | input | 1 | Read-data FIFO head is valid |
| fifoTag | input | 3 | Tag of the FIFO head |
| fifoData | input | DATA_W | Data of the FIFO head |
| fifoPop | output | 1 | Consume the FIFO head at this edge |
| tgtReady | input | 1 | Target path can take a data phase |
| tgtValid | output | 1 | Data phase valid |
| tgtData | output | DATA_W | Data phase value |
| tgtLast | output | 1 | Final data phase of the read |
| tgtPerr | output | 1 | Data carries a parity error |
| tgtDisconnect | output | 1 | Disconnect after this partial-word phase |
| tgtAbort | output | 1 | Terminate the read with target abort |
| tgtRetry | output | 1 | Retry the current data phase |
| rspValid | output | 1 | Response to host valid |
| rspCode | output | 4 | Response code (4'h3, 4'h8 or 4'h9) |
| rspData | output | 32 | Response data |

## Verification
The assertions assume that the FIFO head is stable until it is popped. They also assume that the host never leaves more than `MAX_RESTARTS` terminators owed at once. The bench drives the FIFO head itself, one entry per cycle, and presents each entry only for the cycle whose pop it checks. It never opens more than two restarts before the terminators arrive. Every scenario finishes well inside the timeout window, except the timeout scenario, which deliberately goes quiet.

// File: rtl/dlyRdPkg.sv
package dlyRdPkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_FLUSH,
    ST_SERVE
  } rdState_t;

  typedef struct packed {
    logic capture;
    logic popFwd;
    logic emitRestart;
    logic emitResume;
    logic emitTimeout;
  } ctlStrobe_t;

  localparam logic [3:0] RSP_REPORT  = 4'h3;
  localparam logic [3:0] RSP_RESTART = 4'h8;
  localparam logic [3:0] RSP_RESUME  = 4'h9;
  localparam int         TIMEOUT_BIT = 18;

  function automatic logic isSpareTag(input logic [2:0] tag);
    return (tag[2] == 1'b0) && (tag[0] == 1'b0);
  endfunction

  function automatic logic isTermTag(input logic [2:0] tag);
    return (tag == 3'b001) || (tag[2:1] == 2'b11);
  endfunction

endpackage

// File: rtl/dlyRdCtrl.sv
module dlyRdCtrl
  import dlyRdPkg::*;
#(
  parameter int TIMEOUT_CYCLES = 256,
  parameter int MAX_RESTARTS   = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rdReqValid,
  input  logic        reMatch,
  input  logic        overlapHit,
  input  logic        writesDrained,
  input  logic        fifoValid,
  input  logic [2:0]  fifoTag,
  input  logic        tgtReady,
  output logic        fifoPop,
  output ctlStrobe_t  strobe
);

  localparam int TMR_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam int CNT_W = $clog2(MAX_RESTARTS + 1);

  rdState_t           state, nextState;
  logic [TMR_W-1:0]   timer;
  logic [CNT_W-1:0]   flushCnt, flushCntNext;
  logic               served;
  logic               spare, term, timerLive, timeoutHit;

  always_comb begin
    spare      = isSpareTag(fifoTag);
    term       = isTermTag(fifoTag);
    timerLive  = (state == ST_WAIT) || (state == ST_SERVE);
    timeoutHit = timerLive && !reMatch && (timer == TMR_W'(TIMEOUT_CYCLES - 1));
  end

  always_comb begin
    strobe       = '0;
    fifoPop      = 1'b0;
    nextState    = state;
    flushCntNext = flushCnt;
    case (state)
      ST_IDLE: begin
        fifoPop = fifoValid && spare;
        if (rdReqValid) begin
          strobe.capture = 1'b1;
          nextState      = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (timeoutHit) begin
          strobe.emitTimeout = 1'b1;
          nextState          = ST_IDLE;
        end else if (overlapHit) begin
          strobe.emitRestart = 1'b1;
          flushCntNext       = CNT_W'(1);
          nextState          = ST_FLUSH;
        end else begin
          fifoPop = fifoValid && spare;
          if (writesDrained) begin
            strobe.emitResume = 1'b1;
            nextState         = ST_SERVE;
          end
        end
      end
      ST_SERVE: begin
        if (timeoutHit) begin
          strobe.emitTimeout = 1'b1;
          nextState          = ST_IDLE;
        end else if (overlapHit) begin
          strobe.emitRestart = 1'b1;
          flushCntNext       = CNT_W'(1);
          nextState          = ST_FLUSH;
        end else if (fifoValid && (spare || tgtReady)) begin
          fifoPop = 1'b1;
          if (!spare) begin
            strobe.popFwd = 1'b1;
            if (term) nextState = ST_IDLE;
          end
        end
      end
      ST_FLUSH: begin
        fifoPop            = fifoValid;
        strobe.emitRestart = overlapHit;
        flushCntNext       = flushCnt + CNT_W'(overlapHit) - CNT_W'(fifoValid && term);
        if (flushCntNext == '0) nextState = served ? ST_SERVE : ST_WAIT;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      flushCnt <= '0;
      served   <= 1'b0;
      timer    <= '0;
    end else begin
      state    <= nextState;
      flushCnt <= flushCntNext;
      if (strobe.capture) served <= 1'b0;
      else if (strobe.emitResume) served <= 1'b1;
      if (strobe.capture || (reMatch && state != ST_IDLE)) timer <= '0;
      else if (timerLive) timer <= timer + TMR_W'(1);
    end
  end

  // R4: flushing always owes at least one terminator
  a_r4_flush_has_debt: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FLUSH) |-> (flushCnt != '0));

  // R6: a read that forwards a last or abort entry is idle next cycle
  a_r6_term_ends_read: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.popFwd && term) |=> (state == ST_IDLE));

  // R11: the timer never passes the limit while it runs
  a_r11_timer_bounded: assert property (@(posedge clk) disable iff (!rstN)
    timerLive |-> (timer < TMR_W'(TIMEOUT_CYCLES)));

endmodule

// File: rtl/dlyRdPath.sv
module dlyRdPath
  import dlyRdPkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int DATA_W       = 32,
  parameter int WINDOW_WORDS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic              rdReqValid,
  input  logic [ADDR_W-1:0] rdReqAddr,
  input  logic [3:0]        rdReqBeN,
  input  logic              wrDoneValid,
  input  logic [ADDR_W-1:0] wrDoneAddr,
  input  logic [2:0]        fifoTag,
  input  logic [DATA_W-1:0] fifoData,
  output logic              reMatch,
  output logic              overlapHit,
  output logic              tgtValid,
  output logic [DATA_W-1:0] tgtData,
  output logic              tgtLast,
  output logic              tgtPerr,
  output logic              tgtDisconnect,
  output logic              tgtAbort,
  output logic              tgtRetry,
  output logic              rspValid,
  output logic [3:0]        rspCode,
  output logic [31:0]       rspData
);

  localparam logic [ADDR_W-1:0] WINDOW_BYTES = ADDR_W'(WINDOW_WORDS * 4);

  logic [ADDR_W-1:0] startAddr;
  logic [3:0]        capBeN;
  logic [ADDR_W-1:0] startAligned, byteOffs;

  always_comb begin
    startAligned = {startAddr[ADDR_W-1:2], 2'b00};
    byteOffs     = wrDoneAddr - startAligned;
    overlapHit   = wrDoneValid && (byteOffs < WINDOW_BYTES);
    reMatch      = rdReqValid && (rdReqAddr == startAddr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startAddr     <= '0;
      capBeN        <= '0;
      tgtValid      <= 1'b0;
      tgtData       <= '0;
      tgtLast       <= 1'b0;
      tgtPerr       <= 1'b0;
      tgtDisconnect <= 1'b0;
      tgtAbort      <= 1'b0;
      tgtRetry      <= 1'b0;
      rspValid      <= 1'b0;
      rspCode       <= '0;
      rspData       <= '0;
    end else begin
      if (strobe.capture) begin
        startAddr <= rdReqAddr;
        capBeN    <= rdReqBeN;
      end
      tgtValid      <= strobe.popFwd && fifoTag[2];
      tgtData       <= (strobe.popFwd && fifoTag[2]) ? fifoData : '0;
      tgtLast       <= strobe.popFwd && fifoTag[2] && fifoTag[1];
      tgtPerr       <= strobe.popFwd && fifoTag[2] && fifoTag[0];
      tgtDisconnect <= strobe.popFwd && fifoTag[2] && (capBeN != 4'b0000);
      tgtAbort      <= strobe.popFwd && (fifoTag == 3'b001);
      tgtRetry      <= strobe.popFwd && (fifoTag == 3'b011);
      rspValid      <= strobe.emitTimeout || strobe.emitRestart || strobe.emitResume;
      if (strobe.emitTimeout) begin
        rspCode <= RSP_REPORT;
        rspData <= 32'(1) << TIMEOUT_BIT;
      end else if (strobe.emitRestart) begin
        rspCode <= RSP_RESTART;
        rspData <= 32'(startAddr);
      end else if (strobe.emitResume) begin
        rspCode <= RSP_RESUME;
        rspData <= 32'(startAddr);
      end else begin
        rspCode <= '0;
        rspData <= '0;
      end
    end
  end

  // R2: a restart response always follows a completed write
  a_r2_restart_after_write: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspCode == RSP_RESTART) |-> $past(wrDoneValid));

  // R7: disconnect only accompanies a data phase
  a_r7_disc_with_data: assert property (@(posedge clk) disable iff (!rstN)
    tgtDisconnect |-> tgtValid);

  // R8: at most one target event per cycle
  a_r8_single_event: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({tgtValid, tgtAbort, tgtRetry}));

endmodule

// File: rtl/delayedReadCtl.sv
module delayedReadCtl
  import dlyRdPkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int DATA_W         = 32,
  parameter int WINDOW_WORDS   = 4,
  parameter int TIMEOUT_CYCLES = 256,
  parameter int MAX_RESTARTS   = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdReqValid,
  input  logic [ADDR_W-1:0] rdReqAddr,
  input  logic [3:0]        rdReqBeN,
  input  logic              writesDrained,
  input  logic              wrDoneValid,
  input  logic [ADDR_W-1:0] wrDoneAddr,
  input  logic              fifoValid,
  input  logic [2:0]        fifoTag,
  input  logic [DATA_W-1:0] fifoData,
  output logic              fifoPop,
  input  logic              tgtReady,
  output logic              tgtValid,
  output logic [DATA_W-1:0] tgtData,
  output logic              tgtLast,
  output logic              tgtPerr,
  output logic              tgtDisconnect,
  output logic              tgtAbort,
  output logic              tgtRetry,
  output logic              rspValid,
  output logic [3:0]        rspCode,
  output logic [31:0]       rspData
);

  ctlStrobe_t strobe;
  logic       reMatch, overlapHit;

  dlyRdCtrl #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .MAX_RESTARTS  (MAX_RESTARTS)
  ) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .rdReqValid   (rdReqValid),
    .reMatch      (reMatch),
    .overlapHit   (overlapHit),
    .writesDrained(writesDrained),
    .fifoValid    (fifoValid),
    .fifoTag      (fifoTag),
    .tgtReady     (tgtReady),
    .fifoPop      (fifoPop),
    .strobe       (strobe)
  );

  dlyRdPath #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .WINDOW_WORDS(WINDOW_WORDS)
  ) uPath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .rdReqValid   (rdReqValid),
    .rdReqAddr    (rdReqAddr),
    .rdReqBeN     (rdReqBeN),
    .wrDoneValid  (wrDoneValid),
    .wrDoneAddr   (wrDoneAddr),
    .fifoTag      (fifoTag),
    .fifoData     (fifoData),
    .reMatch      (reMatch),
    .overlapHit   (overlapHit),
    .tgtValid     (tgtValid),
    .tgtData      (tgtData),
    .tgtLast      (tgtLast),
    .tgtPerr      (tgtPerr),
    .tgtDisconnect(tgtDisconnect),
    .tgtAbort     (tgtAbort),
    .tgtRetry     (tgtRetry),
    .rspValid     (rspValid),
    .rspCode      (rspCode),
    .rspData      (rspData)
  );

  // R1: pops only consume a valid head
  a_r1_pop_needs_head: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> fifoValid);

  // R6: a data phase was accepted while the target was ready
  a_r6_valid_after_ready: assert property (@(posedge clk) disable iff (!rstN)
    tgtValid |-> $past(tgtReady && fifoPop));

  // R9: every target event traces back to a pop
  a_r9_event_from_pop: assert property (@(posedge clk) disable iff (!rstN)
    (tgtValid || tgtAbort || tgtRetry) |-> $past(fifoPop));

endmodule

// File: tb/sim_delayedReadCtl.sv
module sim_delayedReadCtl;

  localparam int TO = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdReqValid = 1'b0;
  logic [31:0] rdReqAddr = '0;
  logic [3:0]  rdReqBeN = '0;
  logic        writesDrained = 1'b0;
  logic        wrDoneValid = 1'b0;
  logic [31:0] wrDoneAddr = '0;
  logic        fifoValid = 1'b0;
  logic [2:0]  fifoTag = '0;
  logic [31:0] fifoData = '0;
  logic        fifoPop;
  logic        tgtReady = 1'b0;
  logic        tgtValid, tgtLast, tgtPerr, tgtDisconnect, tgtAbort, tgtRetry;
  logic [31:0] tgtData;
  logic        rspValid;
  logic [3:0]  rspCode;
  logic [31:0] rspData;

  int nChecks = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  delayedReadCtl #(.TIMEOUT_CYCLES(TO), .WINDOW_WORDS(4)) u0 (
    .clk(clk), .rstN(rstN), .rdReqValid(rdReqValid), .rdReqAddr(rdReqAddr),
    .rdReqBeN(rdReqBeN), .writesDrained(writesDrained), .wrDoneValid(wrDoneValid),
    .wrDoneAddr(wrDoneAddr), .fifoValid(fifoValid), .fifoTag(fifoTag),
    .fifoData(fifoData), .fifoPop(fifoPop), .tgtReady(tgtReady),
    .tgtValid(tgtValid), .tgtData(tgtData), .tgtLast(tgtLast), .tgtPerr(tgtPerr),
    .tgtDisconnect(tgtDisconnect), .tgtAbort(tgtAbort), .tgtRetry(tgtRetry),
    .rspValid(rspValid), .rspCode(rspCode), .rspData(rspData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic expectRsp(input string req, input logic v, input logic [3:0] code,
                           input logic [31:0] data);
    check(req, 32'(rspValid), 32'(v));
    if (v) begin
      check(req, 32'(rspCode), 32'(code));
      check(req, rspData, data);
    end
  endtask

  task automatic expectTgt(input string req, input logic [5:0] flags, input logic [31:0] data);
    check(req, 32'({tgtValid, tgtLast, tgtPerr, tgtDisconnect, tgtAbort, tgtRetry}), 32'(flags));
    if (flags[5]) check(req, tgtData, data);
  endtask

  task automatic startRead(input logic [31:0] addr, input logic [3:0] beN);
    rdReqValid = 1'b1; rdReqAddr = addr; rdReqBeN = beN;
    tick;
    rdReqValid = 1'b0;
  endtask

  task automatic doWrite(input logic [31:0] addr);
    wrDoneValid = 1'b1; wrDoneAddr = addr;
    tick;
    wrDoneValid = 1'b0;
  endtask

  task automatic drain;
    writesDrained = 1'b1;
    tick;
    writesDrained = 1'b0;
  endtask

  task automatic pushEntry(input string req, input logic [2:0] tag, input logic [31:0] data,
                           input logic ready, input logic expPop);
    fifoValid = 1'b1; fifoTag = tag; fifoData = data; tgtReady = ready;
    #1;
    check(req, 32'(fifoPop), 32'(expPop));
    tick;
    fifoValid = 1'b0; tgtReady = 1'b0;
  endtask

  task automatic testReset;
    expectTgt("R1 reset target outputs", 6'b000000, 0);
    expectRsp("R1 reset response", 1'b0, 4'h0, 0);
    pushEntry("R1 idle holds data entry", 3'b100, 32'h1, 1'b1, 1'b0);
    expectTgt("R1 idle no output", 6'b000000, 0);
  endtask

  task automatic testBasic;
    startRead(32'h100, 4'b0000);
    doWrite(32'h200);
    expectRsp("R2 non-overlap silent", 1'b0, 4'h0, 0);
    drain;
    expectRsp("R5 resume", 1'b1, 4'h9, 32'h100);
    tick;
    expectRsp("R5 single pulse", 1'b0, 4'h0, 0);
    pushEntry("R6 waits for ready", 3'b100, 32'hA0, 1'b0, 1'b0);
    expectTgt("R6 nothing without ready", 6'b000000, 0);
    pushEntry("R6 pop data", 3'b100, 32'hA1, 1'b1, 1'b1);
    expectTgt("R6 data phase", 6'b100000, 32'hA1);
    pushEntry("R6 pop perr", 3'b101, 32'hA2, 1'b1, 1'b1);
    expectTgt("R6 perr phase", 6'b101000, 32'hA2);
    pushEntry("R9 pop retry", 3'b011, 32'hA3, 1'b1, 1'b1);
    expectTgt("R9 retry pulse", 6'b000001, 0);
    pushEntry("R10 spare in service", 3'b010, 32'hA4, 1'b0, 1'b1);
    expectTgt("R10 spare silent", 6'b000000, 0);
    pushEntry("R9 read continues", 3'b110, 32'hA5, 1'b1, 1'b1);
    expectTgt("R6 last phase", 6'b110000, 32'hA5);
    pushEntry("R6 read ended", 3'b100, 32'hA6, 1'b1, 1'b0);
    expectTgt("R6 idle after last", 6'b000000, 0);
  endtask

  task automatic testRestart;
    startRead(32'h400, 4'b1100);
    doWrite(32'h410);
    expectRsp("R2 just above window", 1'b0, 4'h0, 0);
    doWrite(32'h3FC);
    expectRsp("R2 just below window", 1'b0, 4'h0, 0);
    doWrite(32'h40C);
    expectRsp("R2 overlap restart", 1'b1, 4'h8, 32'h400);
    pushEntry("R3 flush ignores ready", 3'b100, 32'hB0, 1'b0, 1'b1);
    expectTgt("R3 flushed not forwarded", 6'b000000, 0);
    pushEntry("R3 flush terminator", 3'b111, 32'hB1, 1'b0, 1'b1);
    expectTgt("R3 terminator not forwarded", 6'b000000, 0);
    pushEntry("R3 back to waiting", 3'b100, 32'hB2, 1'b1, 1'b0);
    drain;
    expectRsp("R5 resume after flush", 1'b1, 4'h9, 32'h400);
    pushEntry("R7 pop partial", 3'b100, 32'hB3, 1'b1, 1'b1);
    expectTgt("R7 disconnect", 6'b100100, 32'hB3);
    pushEntry("R8 pop abort", 3'b001, 32'hB4, 1'b1, 1'b1);
    expectTgt("R8 abort pulse", 6'b000010, 0);
    pushEntry("R8 read ended", 3'b100, 32'hB5, 1'b1, 1'b0);
  endtask

  task automatic testMultiRestart;
    startRead(32'h800, 4'b0000);
    startRead(32'h900, 4'b0000);
    doWrite(32'h904);
    expectRsp("R12 other address ignored", 1'b0, 4'h0, 0);
    drain;
    expectRsp("R12 address kept", 1'b1, 4'h9, 32'h800);
    doWrite(32'h800);
    expectRsp("R4 first restart", 1'b1, 4'h8, 32'h800);
    doWrite(32'h808);
    expectRsp("R4 restart during flush", 1'b1, 4'h8, 32'h800);
    pushEntry("R4 first terminator", 3'b110, 32'hC0, 1'b0, 1'b1);
    expectTgt("R4 first term dropped", 6'b000000, 0);
    pushEntry("R4 still flushing", 3'b100, 32'hC1, 1'b0, 1'b1);
    expectTgt("R4 stale dropped", 6'b000000, 0);
    pushEntry("R4 second terminator", 3'b001, 32'hC2, 1'b0, 1'b1);
    expectTgt("R4 abort term dropped", 6'b000000, 0);
    pushEntry("R4 service resumes", 3'b100, 32'hC3, 1'b1, 1'b1);
    expectTgt("R4 data after flush", 6'b100000, 32'hC3);
    pushEntry("R6 close read", 3'b110, 32'hC4, 1'b1, 1'b1);
    expectTgt("R6 close last", 6'b110000, 32'hC4);
  endtask

  task automatic testTimeout;
    startRead(32'hC00, 4'b0000);
    pushEntry("R10 spare while waiting", 3'b010, 32'hD0, 1'b0, 1'b1);
    expectTgt("R10 waiting spare silent", 6'b000000, 0);
    for (int i = 0; i < 8; i++) tick;
    startRead(32'hC00, 4'b0000);
    for (int i = 0; i < TO - 1; i++) begin
      tick;
      check("R11 no early timeout", 32'(rspValid), 32'h0);
    end
    tick;
    expectRsp("R11 timeout report", 1'b1, 4'h3, 32'h0004_0000);
    pushEntry("R10 spare while idle", 3'b000, 32'hD1, 1'b0, 1'b1);
    expectTgt("R10 idle spare silent", 6'b000000, 0);
    pushEntry("R11 read discarded", 3'b100, 32'hD2, 1'b1, 1'b0);
  endtask

  task automatic testPriority;
    startRead(32'h1000, 4'b0000);
    writesDrained = 1'b1;
    doWrite(32'h1004);
    writesDrained = 1'b0;
    expectRsp("R13 restart beats resume", 1'b1, 4'h8, 32'h1000);
    pushEntry("R13 flush term", 3'b110, 32'hE0, 1'b0, 1'b1);
    drain;
    expectRsp("R13 resume later", 1'b1, 4'h9, 32'h1000);
    pushEntry("R6 last perr", 3'b111, 32'hE1, 1'b1, 1'b1);
    expectTgt("R6 last with perr", 6'b111000, 32'hE1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) tick;
    rstN = 1'b1;
    tick;
    testReset;
    testBasic;
    testRestart;
    testMultiRestart;
    testTimeout;
    testPriority;
    repeat (2) tick;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule